// File: doc/BRIEF.md
# DisplayPort AUX Transaction Controller

This block lets a host run one DisplayPort AUX request at a time through a small bank of byte-wide registers. The host sets a command nibble, a 20-bit address and a length, and loads a 16-byte data buffer when the request is a write. It then sets a start bit. The controller sends a request descriptor to a byte-level link port and, for writes, streams the buffer after it. It then waits for the reply. The first reply byte is the reply code, and for reads the bytes that follow are stored in the buffer.

Completion is shown by a start bit that clears itself and by reply and error flags that are cleared by writing one to them. A native defer (code 0x2) or an I2C defer (code 0x8) is retried automatically after a selectable interval, counted in microsecond ticks, until the defer budget is used up. A silent link is retried the same way on a separate budget and is finally reported as a timeout. The line coding and the analog path sit outside the block, behind the byte port.

The sequencer is one state machine with six states:
- `ST_IDLE`: waits for a start write, then goes to `ST_REQ`.
- `ST_REQ`: pulses the descriptor for one cycle. It goes to `ST_TXDATA` for a write with data, and to `ST_WAIT` otherwise.
- `ST_TXDATA`: streams the data bytes, then goes to `ST_WAIT`.
- `ST_WAIT`: takes the reply code. It goes to `ST_RXDATA` for read data, to `ST_GAP` on a defer that still has budget or on a timeout that still has budget, and back to `ST_IDLE` on a final reply or on a final timeout.
- `ST_RXDATA`: stores the read bytes. It returns to `ST_IDLE` on the last byte, or leaves on a timeout as `ST_WAIT` does.
- `ST_GAP`: waits out the retry interval, then returns to `ST_REQ`.

Top module: `aux_xact_ctrl`

Register word indices (`reg_addr`):

| Index | Register | Contents |
|---|---|---|
| 0 | CMD | length-1 in bits 7:4, command in bits 3:0 |
| 1 | ADDR0 | address bits 7:0 |
| 2 | ADDR1 | address bits 15:8 |
| 3 | ADDR2 | address bits 19:16 |
| 4 | START | start bit 0, address-only bit 1 |
| 5 | IRQ | reply flag bit 1, error flag bit 0 |
| 6 | CHSTA | busy bit 4, status code bits 3:0 |
| 7 | RXCMD | last reply code |
| 8 | RETRY | interval select bits 4:3, timeout retry count bits 2:0 |
| 9 | DEFER | enable bit 7, defer count bits 3:0 |
| 10 | BUFCTL | clear bit 7 |
| 32..47 | buffer | bytes 0..15 |

## Requirements
- R1: After reset, START, IRQ, CHSTA and RXCMD all read 0, and no descriptor or data byte is driven.
- R2: A start write (START bit 0 = 1) gives exactly one cycle of `lnk_req_valid`. During that cycle the descriptor carries the CMD command nibble (bit 3 selects native rather than I2C, bit 2 is the I2C middle-of-transaction flag, bit 0 selects read), the length-1 field from CMD bits 7:4, and the 20-bit address assembled from ADDR2:ADDR1:ADDR0.
- R3: For a write (command bit 0 = 0) that is not address-only, the cycles right after the descriptor carry length-1+1 data bytes, buffer byte 0 first, one per cycle.
- R4: For a read, a reply code of 0x0 followed by data bytes stores those bytes in the buffer from index 0 upward, and `lnk_rx_last` ends the reply.
- R5: START bit 0 reads 1 while a transaction runs and clears itself when it ends. A completed reply sets IRQ bit 1 and CHSTA status 0, records the code in RXCMD, and both IRQ bits are cleared by writing 1 to them.
- R6: A start write with START bit 1 also set makes the request address-only. The descriptor flag is set and no data bytes are sent, even for a write command.
- R7: A reply code of 0x2 or 0x8, while DEFER bit 7 is set and the remaining defer budget (loaded from DEFER bits 3:0 at start) is nonzero, starts a new attempt. The new descriptor follows after the interval chosen by RETRY bits 4:3 (600, 800, 1000 or 1800 ticks of `us_tick`).
- R8: A defer reply that arrives with no budget left ends the transaction. It sets IRQ bit 1, leaves status 0 and puts the defer code in RXCMD.
- R9: A reply code other than 0x0, 0x2 or 0x8 sets both IRQ bits, CHSTA status 2, and RXCMD to that code.
- R10: If no reply byte arrives for TIMEOUT_CYC cycles, the request is reissued after the interval while the retry budget (RETRY bits 2:0) remains. After that the transaction ends with IRQ bit 0 set, CHSTA status 1 and the start bit clear.
- R11: While busy, host writes to CMD, ADDR0-2, START, BUFCTL and the buffer are ignored.
- R12: Writing 1 to BUFCTL bit 7 while idle clears all buffer bytes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| us_tick | input | 1 | one-cycle pulse per microsecond |
| reg_wr | input | 1 | host register write strobe |
| reg_addr | input | 6 | host register word index |
| reg_wdata | input | 8 | host write data |
| reg_rdata | output | 8 | host read data for reg_addr |
| lnk_req_valid | output | 1 | descriptor valid, one cycle |
| lnk_req_cmd | output | 4 | request command nibble |
| lnk_req_addr | output | 20 | request address |
| lnk_req_len | output | 4 | request length minus one |
| lnk_req_addr_only | output | 1 | address-only request |
| lnk_tx_valid | output | 1 | outgoing data byte valid |
| lnk_tx_data | output | 8 | outgoing data byte |
| lnk_rx_valid | input | 1 | reply byte valid |
| lnk_rx_data | input | 8 | reply byte (code first, then data) |
| lnk_rx_last | input | 1 | marks the last reply byte |

## Verification
The assertions assume that the link responder sends reply bytes only after the descriptor and its data bytes have gone out, and never while a retry gap is running. They also assume that `us_tick` is a clean single-cycle pulse. The bench responder starts each reply only after it has seen the descriptor and has collected the expected data bytes. It holds `us_tick` high on every cycle, so each interval takes a known number of cycles. The host writes made during busy periods fall between descriptor and reply, which keeps them inside the window where they are meant to be dropped.

// File: rtl/auxc_pkg.sv
`timescale 1ns/1ps
package auxc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_TXDATA,
        ST_WAIT,
        ST_RXDATA,
        ST_GAP
    } auxc_state_e;

    localparam logic [3:0] RX_ACK          = 4'h0;
    localparam logic [3:0] RX_NATIVE_DEFER = 4'h2;
    localparam logic [3:0] RX_I2C_DEFER    = 4'h8;

    localparam logic [3:0] STAT_OK      = 4'd0;
    localparam logic [3:0] STAT_TIMEOUT = 4'd1;
    localparam logic [3:0] STAT_NACK    = 4'd2;

    localparam logic [5:0] RI_CMD    = 6'd0;
    localparam logic [5:0] RI_ADDR0  = 6'd1;
    localparam logic [5:0] RI_ADDR1  = 6'd2;
    localparam logic [5:0] RI_ADDR2  = 6'd3;
    localparam logic [5:0] RI_START  = 6'd4;
    localparam logic [5:0] RI_IRQ    = 6'd5;
    localparam logic [5:0] RI_CHSTA  = 6'd6;
    localparam logic [5:0] RI_RXCMD  = 6'd7;
    localparam logic [5:0] RI_RETRY  = 6'd8;
    localparam logic [5:0] RI_DEFER  = 6'd9;
    localparam logic [5:0] RI_BUFCTL = 6'd10;

    function automatic int unsigned gap_ticks(input logic [1:0] sel);
        case (sel)
            2'd0:    return 600;
            2'd1:    return 800;
            2'd2:    return 1000;
            default: return 1800;
        endcase
    endfunction

endpackage

// File: rtl/auxc_backoff.sv
`timescale 1ns/1ps
module auxc_backoff #(
    parameter int unsigned CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       us_tick,
    input  logic [1:0] sel,
    output logic       done
);
    import auxc_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_m1;

    assign limit_m1 = CNT_W'(gap_ticks(sel) - 1);
    assign done     = run && us_tick && (cnt == limit_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (us_tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/auxc_data_buf.sv
`timescale 1ns/1ps
module auxc_data_buf #(
    parameter int unsigned BYTES = 16,
    localparam int unsigned AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_idx_a,
    output logic [7:0]    rd_data_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [7:0]    rd_data_b
);
    logic [BYTES-1:0][7:0] mem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < BYTES; i++) begin
                if (clr)                                 mem[i] <= 8'h00;
                else if (wr_en && wr_idx == AW'(i))      mem[i] <= wr_data;
            end
        end
    end

    assign rd_data_a = mem[rd_idx_a];
    assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/aux_xact_ctrl.sv
`timescale 1ns/1ps
module aux_xact_ctrl #(
    parameter int unsigned BUF_BYTES   = 16,
    parameter int unsigned TIMEOUT_CYC = 512,
    localparam int unsigned BUF_AW     = $clog2(BUF_BYTES),
    localparam int unsigned TMO_W      = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        us_tick,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        lnk_req_valid,
    output logic [3:0]  lnk_req_cmd,
    output logic [19:0] lnk_req_addr,
    output logic [3:0]  lnk_req_len,
    output logic        lnk_req_addr_only,
    output logic        lnk_tx_valid,
    output logic [7:0]  lnk_tx_data,
    input  logic        lnk_rx_valid,
    input  logic [7:0]  lnk_rx_data,
    input  logic        lnk_rx_last
);
    import auxc_pkg::*;

    auxc_state_e state_q, state_d;

    logic [3:0]        cmd_q;
    logic [BUF_AW-1:0] len_q;
    logic [19:0]       addr_q;
    logic              aonly_q;
    logic              irq_reply, irq_err;
    logic [3:0]        status_q, rxcmd_q;
    logic [4:0]        retry_cfg;
    logic              defer_en_q;
    logic [3:0]        defer_cnt_q, defer_left;
    logic [2:0]        retry_left;
    logic [BUF_AW-1:0] tx_idx, rx_idx;
    logic [TMO_W-1:0]  tmo_cnt;

    logic busy, host_ok, start_req, waiting, tmo_hit, gap_done;
    logic ev_done_reply, ev_tmo_retry, ev_tmo_fail, ev_defer_retry, rx_store;
    logic [3:0] rx_code, done_code;
    logic rx_defer, done_defer;
    logic host_buf_wr, buf_clr, buf_wr_en;
    logic [BUF_AW-1:0] buf_wr_idx;
    logic [7:0] buf_wr_data, buf_host_rd, buf_tx_rd;

    assign busy      = (state_q != ST_IDLE);
    assign host_ok   = reg_wr && !busy;
    assign start_req = host_ok && (reg_addr == RI_START) && reg_wdata[0];
    assign waiting   = (state_q == ST_WAIT) || (state_q == ST_RXDATA);
    assign tmo_hit   = waiting && !lnk_rx_valid && (tmo_cnt == TMO_W'(TIMEOUT_CYC - 1));
    assign rx_code   = lnk_rx_data[3:0];
    assign rx_defer  = (rx_code == RX_NATIVE_DEFER) || (rx_code == RX_I2C_DEFER);
    assign done_code = (state_q == ST_RXDATA) ? RX_ACK : rx_code;
    assign done_defer = (done_code == RX_NATIVE_DEFER) || (done_code == RX_I2C_DEFER);

    // next-state decision
    always_comb begin
        state_d        = state_q;
        ev_done_reply  = 1'b0;
        ev_tmo_retry   = 1'b0;
        ev_tmo_fail    = 1'b0;
        ev_defer_retry = 1'b0;
        rx_store       = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_REQ;
            ST_REQ:    state_d = (!cmd_q[0] && !aonly_q) ? ST_TXDATA : ST_WAIT;
            ST_TXDATA: if (tx_idx == len_q) state_d = ST_WAIT;
            ST_WAIT: begin
                if (lnk_rx_valid) begin
                    if (rx_defer && defer_en_q && defer_left != 4'd0) begin
                        state_d = ST_GAP;  ev_defer_retry = 1'b1;
                    end else if (rx_code == RX_ACK && cmd_q[0] && !aonly_q && !lnk_rx_last) begin
                        state_d = ST_RXDATA;
                    end else begin
                        state_d = ST_IDLE; ev_done_reply = 1'b1;
                    end
                end else if (tmo_hit) begin
                    if (retry_left != 3'd0) begin state_d = ST_GAP;  ev_tmo_retry = 1'b1; end
                    else                    begin state_d = ST_IDLE; ev_tmo_fail  = 1'b1; end
                end
            end
            ST_RXDATA: begin
                if (lnk_rx_valid) begin
                    rx_store = 1'b1;
                    if (lnk_rx_last) begin state_d = ST_IDLE; ev_done_reply = 1'b1; end
                end else if (tmo_hit) begin
                    if (retry_left != 3'd0) begin state_d = ST_GAP;  ev_tmo_retry = 1'b1; end
                    else                    begin state_d = ST_IDLE; ev_tmo_fail  = 1'b1; end
                end
            end
            ST_GAP:    if (gap_done) state_d = ST_REQ;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registers, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0; len_q <= '0; addr_q <= '0; aonly_q <= 1'b0;
            irq_reply <= 1'b0; irq_err <= 1'b0; status_q <= STAT_OK; rxcmd_q <= '0;
            retry_cfg <= '0; defer_en_q <= 1'b0; defer_cnt_q <= '0;
            defer_left <= '0; retry_left <= '0; tx_idx <= '0; rx_idx <= '0; tmo_cnt <= '0;
        end else begin
            if (host_ok) begin
                case (reg_addr)
                    RI_CMD:   begin len_q <= reg_wdata[4 +: BUF_AW]; cmd_q <= reg_wdata[3:0]; end
                    RI_ADDR0: addr_q[7:0]   <= reg_wdata;
                    RI_ADDR1: addr_q[15:8]  <= reg_wdata;
                    RI_ADDR2: addr_q[19:16] <= reg_wdata[3:0];
                    RI_START: if (reg_wdata[0]) aonly_q <= reg_wdata[1];
                    default: ;
                endcase
            end
            if (reg_wr && reg_addr == RI_RETRY) retry_cfg <= reg_wdata[4:0];
            if (reg_wr && reg_addr == RI_DEFER) begin
                defer_en_q  <= reg_wdata[7];
                defer_cnt_q <= reg_wdata[3:0];
            end
            if (reg_wr && reg_addr == RI_IRQ) begin
                if (reg_wdata[1]) irq_reply <= 1'b0;
                if (reg_wdata[0]) irq_err   <= 1'b0;
            end
            if (start_req) begin
                defer_left <= defer_cnt_q;
                retry_left <= retry_cfg[2:0];
                status_q   <= STAT_OK;
            end
            if (ev_defer_retry) defer_left <= defer_left - 1'b1;
            if (ev_tmo_retry)   retry_left <= retry_left - 1'b1;
            if (ev_done_reply) begin
                irq_reply <= 1'b1;
                rxcmd_q   <= done_code;
                if (done_code == RX_ACK || done_defer) status_q <= STAT_OK;
                else begin irq_err <= 1'b1; status_q <= STAT_NACK; end
            end
            if (ev_tmo_fail) begin
                irq_err  <= 1'b1;
                status_q <= STAT_TIMEOUT;
            end
            if (state_q == ST_REQ)         tx_idx <= '0;
            else if (state_q == ST_TXDATA) tx_idx <= tx_idx + 1'b1;
            if (state_q == ST_REQ)         rx_idx <= '0;
            else if (rx_store)             rx_idx <= rx_idx + 1'b1;
            if (!waiting || lnk_rx_valid)  tmo_cnt <= '0;
            else                           tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    assign host_buf_wr = host_ok && reg_addr[5];
    assign buf_clr     = host_ok && (reg_addr == RI_BUFCTL) && reg_wdata[7];
    assign buf_wr_en   = rx_store || host_buf_wr;
    assign buf_wr_idx  = rx_store ? rx_idx : reg_addr[BUF_AW-1:0];
    assign buf_wr_data = rx_store ? lnk_rx_data : reg_wdata;

    auxc_data_buf #(.BYTES(BUF_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wr_data),
        .rd_idx_a(reg_addr[BUF_AW-1:0]), .rd_data_a(buf_host_rd),
        .rd_idx_b(tx_idx), .rd_data_b(buf_tx_rd)
    );

    auxc_backoff #(.CNT_W(11)) u_gap (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_GAP),
        .us_tick(us_tick), .sel(retry_cfg[4:3]), .done(gap_done)
    );

    // outputs
    always_comb begin
        lnk_req_valid     = (state_q == ST_REQ);
        lnk_req_cmd       = cmd_q;
        lnk_req_addr      = addr_q;
        lnk_req_len       = 4'(len_q);
        lnk_req_addr_only = aonly_q;
        lnk_tx_valid      = (state_q == ST_TXDATA);
        lnk_tx_data       = buf_tx_rd;
        if (reg_addr[5]) begin
            reg_rdata = buf_host_rd;
        end else begin
            case (reg_addr)
                RI_CMD:   reg_rdata = 8'({len_q, cmd_q});
                RI_ADDR0: reg_rdata = addr_q[7:0];
                RI_ADDR1: reg_rdata = addr_q[15:8];
                RI_ADDR2: reg_rdata = {4'h0, addr_q[19:16]};
                RI_START: reg_rdata = {6'h0, aonly_q, busy};
                RI_IRQ:   reg_rdata = {6'h0, irq_reply, irq_err};
                RI_CHSTA: reg_rdata = {3'h0, busy, status_q};
                RI_RXCMD: reg_rdata = {4'h0, rxcmd_q};
                RI_RETRY: reg_rdata = {3'h0, retry_cfg};
                RI_DEFER: reg_rdata = {defer_en_q, 3'h0, defer_cnt_q};
                default:  reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/aux_xact_ctrl_chk.sv
`timescale 1ns/1ps
module aux_xact_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        lnk_req_valid,
    input logic        lnk_tx_valid,
    input logic [3:0]  lnk_req_cmd,
    input logic        lnk_req_addr_only,
    input logic [19:0] lnk_req_addr,
    input logic        irq_reply,
    input logic        irq_err,
    input logic        ev_tmo_fail
);
    // R2: descriptor lasts one cycle
    a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_req_valid |=> !lnk_req_valid);

    // R3 and R6: data bytes only for non-address-only writes
    a_r6_tx_only_for_data_writes: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_tx_valid |-> (!lnk_req_addr_only && !lnk_req_cmd[0]));

    // R5: end of a transaction always leaves a flag behind
    a_r5_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (irq_reply || irq_err));

    // R10: final timeout raises the error flag and releases busy
    a_r10_timeout_error: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmo_fail |=> (irq_err && !busy));

    // R11: address frozen while busy
    a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lnk_req_addr));

    // R2: descriptor and data never overlap
    a_r2_req_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lnk_req_valid, lnk_tx_valid}));
endmodule

bind aux_xact_ctrl aux_xact_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .lnk_req_valid(lnk_req_valid), .lnk_tx_valid(lnk_tx_valid),
    .lnk_req_cmd(lnk_req_cmd), .lnk_req_addr_only(lnk_req_addr_only),
    .lnk_req_addr(lnk_req_addr), .irq_reply(irq_reply), .irq_err(irq_err),
    .ev_tmo_fail(ev_tmo_fail)
);

// File: tb/tb_aux_xact_ctrl.sv
`timescale 1ns/1ps
module tb_aux_xact_ctrl;
    localparam logic [5:0] A_CMD = 0, A_ADDR0 = 1, A_ADDR1 = 2, A_ADDR2 = 3, A_START = 4,
                           A_IRQ = 5, A_CHSTA = 6, A_RXCMD = 7, A_RETRY = 8, A_DEFER = 9,
                           A_BUFCTL = 10, A_BUF = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b1;
    logic reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic lnk_req_valid, lnk_req_addr_only, lnk_tx_valid;
    logic [3:0] lnk_req_cmd, lnk_req_len;
    logic [19:0] lnk_req_addr;
    logic [7:0] lnk_tx_data;
    logic lnk_rx_valid = 1'b0, lnk_rx_last = 1'b0;
    logic [7:0] lnk_rx_data = '0;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    aux_xact_ctrl dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lnk_req_valid(lnk_req_valid), .lnk_req_cmd(lnk_req_cmd), .lnk_req_addr(lnk_req_addr),
        .lnk_req_len(lnk_req_len), .lnk_req_addr_only(lnk_req_addr_only),
        .lnk_tx_valid(lnk_tx_valid), .lnk_tx_data(lnk_tx_data),
        .lnk_rx_valid(lnk_rx_valid), .lnk_rx_data(lnk_rx_data), .lnk_rx_last(lnk_rx_last)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, act %0d cycles exp fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: act %0d exp %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!lnk_req_valid) begin @(negedge clk); n++; end
    endtask

    task automatic collect_tx(input string tag, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " tx valid"}, lnk_tx_valid, 1'b1);
            chk({tag, " tx byte"}, lnk_tx_data, base + 8'(i));
        end
        @(negedge clk);
        chk({tag, " tx stops"}, lnk_tx_valid, 1'b0);
    endtask

    task automatic send_reply(input logic [7:0] code, input int n, input logic [7:0] base);
        @(negedge clk); lnk_rx_valid = 1'b1; lnk_rx_data = code; lnk_rx_last = (n == 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lnk_rx_data = base + 8'(i); lnk_rx_last = (i == n - 1);
        end
        @(negedge clk); lnk_rx_valid = 1'b0; lnk_rx_last = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 START", A_START, 8'h00);
        rd_chk("R1 IRQ", A_IRQ, 8'h00);
        rd_chk("R1 CHSTA", A_CHSTA, 8'h00);
        rd_chk("R1 RXCMD", A_RXCMD, 8'h00);
        chk("R1 no req", lnk_req_valid, 1'b0);
        chk("R1 no tx", lnk_tx_valid, 1'b0);

        // R2 R3 R5: native write of 3 bytes to 0x12345
        for (int i = 0; i < 3; i++) wr(A_BUF + 6'(i), 8'hA0 + 8'(i));
        wr(A_CMD, 8'h28);
        wr(A_ADDR0, 8'h45); wr(A_ADDR1, 8'h23); wr(A_ADDR2, 8'h01);
        wr(A_START, 8'h01);
        wait_req(n);
        chk("R2 cmd", lnk_req_cmd, 4'h8);
        chk("R2 addr", lnk_req_addr, 20'h12345);
        chk("R2 len", lnk_req_len, 4'd2);
        chk("R2 aonly", lnk_req_addr_only, 1'b0);
        collect_tx("R3", 3, 8'hA0);
        send_reply(8'h00, 0, 8'h00);
        rd_chk("R5 reply flag", A_IRQ, 8'h02);
        rd_chk("R5 status ok", A_CHSTA, 8'h00);
        rd_chk("R5 start self-clears", A_START, 8'h00);
        wr(A_IRQ, 8'h02);
        rd_chk("R5 w1c", A_IRQ, 8'h00);

        // R4: native read of 4 bytes
        wr(A_CMD, 8'h39); wr(A_ADDR0, 8'h10); wr(A_ADDR1, 8'h00); wr(A_ADDR2, 8'h00);
        wr(A_START, 8'h01);
        wait_req(n);
        chk("R2 read cmd", lnk_req_cmd, 4'h9);
        chk("R2 read len", lnk_req_len, 4'd3);
        rd_chk("R5 busy bit", A_START, 8'h01);
        send_reply(8'h00, 4, 8'h5A);
        for (int i = 0; i < 4; i++) rd_chk("R4 read data", A_BUF + 6'(i), 8'h5A + 8'(i));
        rd_chk("R4 reply flag", A_IRQ, 8'h02);
        rd_chk("R4 rxcmd", A_RXCMD, 8'h00);
        wr(A_IRQ, 8'h03);

        // R6: address-only native write
        wr(A_CMD, 8'h08); wr(A_START, 8'h03);
        wait_req(n);
        chk("R6 aonly flag", lnk_req_addr_only, 1'b1);
        @(negedge clk);
        chk("R6 no data", lnk_tx_valid, 1'b0);
        send_reply(8'h00, 0, 8'h00);
        rd_chk("R6 done", A_IRQ, 8'h02);
        rd_chk("R6 start clear", A_START, 8'h02);
        wr(A_IRQ, 8'h03);

        // R7: native defer retried after 600 ticks
        wr(A_DEFER, 8'h81); wr(A_RETRY, 8'h00);
        wr(A_CMD, 8'h39); wr(A_START, 8'h01);
        wait_req(n);
        send_reply(8'h02, 0, 8'h00);
        wait_req(n);
        chk_rng("R7 gap 600", n, 595, 605);
        chk("R7 same cmd", lnk_req_cmd, 4'h9);
        send_reply(8'h00, 4, 8'h70);
        rd_chk("R7 data after retry", A_BUF, 8'h70);
        rd_chk("R7 rxcmd ack", A_RXCMD, 8'h00);
        rd_chk("R7 reply flag", A_IRQ, 8'h02);
        wr(A_IRQ, 8'h03);

        // R7 R8: I2C defer, 800-tick interval, budget exhausted
        wr(A_RETRY, 8'h08);
        wr(A_CMD, 8'h31); wr(A_START, 8'h01);
        wait_req(n);
        send_reply(8'h08, 0, 8'h00);
        wait_req(n);
        chk_rng("R7 gap 800", n, 795, 805);
        send_reply(8'h08, 0, 8'h00);
        rd_chk("R8 defer reported", A_RXCMD, 8'h08);
        rd_chk("R8 reply only", A_IRQ, 8'h02);
        rd_chk("R8 status ok", A_CHSTA, 8'h00);
        wr(A_IRQ, 8'h03);

        // R9: nack
        wr(A_DEFER, 8'h00); wr(A_BUF, 8'h11);
        wr(A_CMD, 8'h08); wr(A_START, 8'h01);
        wait_req(n);
        collect_tx("R9", 1, 8'h11);
        send_reply(8'h01, 0, 8'h00);
        rd_chk("R9 both flags", A_IRQ, 8'h03);
        rd_chk("R9 status nack", A_CHSTA, 8'h02);
        rd_chk("R9 rxcmd", A_RXCMD, 8'h01);
        wr(A_IRQ, 8'h03);

        // R10: timeout, one retry, then failure
        wr(A_RETRY, 8'h01);
        wr(A_CMD, 8'h09); wr(A_START, 8'h01);
        wait_req(n);
        @(negedge clk);
        wait_req(n);
        chk_rng("R10 reissue after timeout", n, 1105, 1118);
        repeat (600) @(negedge clk);
        rd_chk("R10 err flag", A_IRQ, 8'h01);
        rd_chk("R10 status timeout", A_CHSTA, 8'h01);
        rd_chk("R10 start clear", A_START, 8'h00);
        wr(A_IRQ, 8'h03);

        // R11: writes ignored while busy
        wr(A_RETRY, 8'h00);
        wr(A_ADDR0, 8'h11); wr(A_ADDR1, 8'h22); wr(A_ADDR2, 8'h03); wr(A_BUF + 6'd1, 8'h99);
        wr(A_CMD, 8'h09); wr(A_START, 8'h01);
        wait_req(n);
        wr(A_ADDR0, 8'hFF); wr(A_BUF + 6'd1, 8'hEE); wr(A_BUFCTL, 8'h80); wr(A_CMD, 8'h00);
        send_reply(8'h00, 1, 8'h44);
        rd_chk("R11 addr kept", A_ADDR0, 8'h11);
        rd_chk("R11 cmd kept", A_CMD, 8'h09);
        rd_chk("R11 buf kept", A_BUF + 6'd1, 8'h99);
        rd_chk("R11 reply data", A_BUF, 8'h44);
        wr(A_IRQ, 8'h03);

        // R12: buffer clear
        wr(A_BUFCTL, 8'h80);
        rd_chk("R12 byte0 cleared", A_BUF, 8'h00);
        rd_chk("R12 byte1 cleared", A_BUF + 6'd1, 8'h00);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule